// File: doc/BRIEF.md
# Branch-and-Exchange Fetch Sequencer

This block is the instruction-fetch front end for a core that executes in two instruction-width states: a wide state with 4-byte instructions and a narrow state with 2-byte instructions. When decode hands it a branch-and-exchange request, the block runs a fixed three-cycle fetch sequence. The request may optionally link. Its target is either a register value or the branch address plus an immediate offset. Over the sequence the block selects the new target and the new state. It drives the fetch address, the sequential/nonsequential qualifier and the state indicator. When linking is requested, it also produces the return address for the link register.

In the first cycle the fetch unit still issues the prefetch that is already committed from the old stream. The second cycle fetches the target as a nonsequential access. The third cycle fetches the next instruction in the new width as a sequential access. The data side of the pipeline may finish the preceding instruction's transfer only in the first cycle. The block raises a busy flag during the first two cycles so that the pipeline stalls. A new request may be taken in the third cycle, so branches can follow each other with no gap.

Top module: `bx_fetch_seq`

## Requirements
- R1: A request is taken only when `busy` is low. `busy` is high in cycles 1 and 2 of a sequence and low in cycle 3 and when idle. A request held high during cycles 1 and 2 has no effect.
- R2: In cycle 1, `fetch_addr` is the branch address plus twice the old instruction width, with `fetch_seq`=1.
- R3: In cycle 2, `fetch_addr` is the selected target, with `fetch_seq`=0 (nonsequential).
- R4: In cycle 3, `fetch_addr` is the target plus the new instruction width (2 for narrow, 4 for wide), with `fetch_seq`=1.
- R5: Register form (`req_imm`=0). The new state is `reg_val` bit 0, where 1 selects the narrow state. The target is `reg_val` with bit 0 cleared, and with bit 1 also cleared when the wide state is entered.
- R6: Immediate form (`req_imm`=1). The new state is always the inverse of `cur_narrow`. The target is `cur_pc + imm_off`, aligned by the same rule as R5.
- R7: `state_out` shows the new state (1 = narrow) in all three cycles. When idle it follows `cur_narrow`.
- R8: With `req_link`=1, `link_we` pulses for exactly one cycle, in cycle 2, and `link_data` is then the branch address plus the old width. With `req_link`=0, `link_we` stays low.
- R9: `dside_en` is high when idle and in cycle 1, and low in cycles 2 and 3.
- R10: After reset the block is idle: `fetch_valid`, `busy` and `link_we` are low. `fetch_valid` is high in exactly the three cycles of a sequence.
- R11: A request presented in cycle 3 starts a new cycle 1 on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Branch-and-exchange request |
| req_imm | input | 1 | 1 = immediate form, 0 = register form |
| req_link | input | 1 | Write a return address to the link register |
| cur_narrow | input | 1 | Current state, 1 = narrow (2-byte) |
| cur_pc | input | AW | Address of the branch instruction |
| reg_val | input | AW | Source register value (register form) |
| imm_off | input | AW | Byte offset from `cur_pc` (immediate form) |
| busy | output | 1 | Pipeline stall, cycles 1 and 2 |
| fetch_valid | output | 1 | Fetch issued this cycle |
| fetch_addr | output | AW | Fetch address |
| fetch_seq | output | 1 | 1 = sequential, 0 = nonsequential |
| state_out | output | 1 | State shown to the fetch side, 1 = narrow |
| dside_en | output | 1 | Data-side transfer permitted this cycle |
| link_we | output | 1 | Link register write enable |
| link_data | output | AW | Return address |

## Verification
A request sampled at a clock edge gives its cycle-1 outputs in the cycle right after that edge. Its target fetch and link write come one cycle later, and its refill fetch one cycle after that. Every output of a sequence is therefore due one, two or three cycles after acceptance. For each request, the driver queues three expected cycle records, each tagged with its cycle number. The monitor samples shortly after every falling edge. On each cycle with a valid fetch it pops exactly one record, so a record that arrives early, late or not at all shows up as a mismatch or as a queue that is not empty at the end. Idle cycles are checked separately for the idle values of busy, state, data-side enable and link strobe.

// File: rtl/bx_fetch_pkg.sv
package bx_fetch_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_C1   = 2'd1,
    PH_C2   = 2'd2,
    PH_C3   = 2'd3
  } bx_phase_e;

  localparam int unsigned NARROW_BYTES = 2;
  localparam int unsigned WIDE_BYTES   = 4;

endpackage

// File: rtl/bx_rst_sync.sv
module bx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bx_target_calc.sv
module bx_target_calc #(
  parameter int unsigned AW = 32
) (
  input  logic          form_imm,
  input  logic          cur_narrow,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] imm_off,
  output logic          new_narrow,
  output logic [AW-1:0] target,
  output logic [AW-1:0] refill,
  output logic [AW-1:0] prefetch,
  output logic [AW-1:0] ret_addr
);
  import bx_fetch_pkg::*;

  localparam logic [AW-1:0] NW = AW'(NARROW_BYTES);
  localparam logic [AW-1:0] WW = AW'(WIDE_BYTES);

  logic [AW-1:0] old_w;
  logic [AW-1:0] new_w;
  logic [AW-1:0] raw;

  always_comb begin
    old_w = cur_narrow ? NW : WW;
    if (form_imm) begin
      new_narrow = ~cur_narrow;
      raw        = pc + imm_off;
    end else begin
      new_narrow = reg_val[0];
      raw        = reg_val;
    end
    new_w     = new_narrow ? NW : WW;
    target    = raw;
    target[0] = 1'b0;
    if (!new_narrow) begin
      target[1] = 1'b0;
    end
    refill   = target + new_w;
    prefetch = pc + (old_w << 1);
    ret_addr = pc + old_w;
  end

endmodule

// File: rtl/bx_phase_ctrl.sv
module bx_phase_ctrl (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    accept,
  output bx_fetch_pkg::bx_phase_e phase
);
  import bx_fetch_pkg::*;

  bx_phase_e phase_q;
  bx_phase_e phase_d;
  logic      open_q;

  always_comb begin
    open_q  = (phase_q == PH_IDLE) || (phase_q == PH_C3);
    accept  = req_valid && open_q;
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: phase_d = accept ? PH_C1 : PH_IDLE;
      PH_C1:   phase_d = PH_C2;
      PH_C2:   phase_d = PH_C3;
      PH_C3:   phase_d = accept ? PH_C1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/bx_fetch_seq.sv
module bx_fetch_seq #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_imm,
  input  logic          req_link,
  input  logic          cur_narrow,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] imm_off,
  output logic          busy,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_seq,
  output logic          state_out,
  output logic          dside_en,
  output logic          link_we,
  output logic [AW-1:0] link_data
);
  import bx_fetch_pkg::*;

  logic          rst_n_int;
  logic          accept;
  bx_phase_e     phase;

  logic          calc_narrow;
  logic [AW-1:0] calc_target;
  logic [AW-1:0] calc_refill;
  logic [AW-1:0] calc_prefetch;
  logic [AW-1:0] calc_ret;

  logic          narrow_q, narrow_d;
  logic          link_q, link_d;
  logic [AW-1:0] target_q, target_d;
  logic [AW-1:0] refill_q, refill_d;
  logic [AW-1:0] prefetch_q, prefetch_d;
  logic [AW-1:0] ret_q, ret_d;

  bx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bx_phase_ctrl u_phase (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .accept    (accept),
    .phase     (phase)
  );

  bx_target_calc #(.AW(AW)) u_calc (
    .form_imm   (req_imm),
    .cur_narrow (cur_narrow),
    .pc         (cur_pc),
    .reg_val    (reg_val),
    .imm_off    (imm_off),
    .new_narrow (calc_narrow),
    .target     (calc_target),
    .refill     (calc_refill),
    .prefetch   (calc_prefetch),
    .ret_addr   (calc_ret)
  );

  // context capture, enabled by accept
  always_comb begin
    narrow_d   = narrow_q;
    link_d     = link_q;
    target_d   = target_q;
    refill_d   = refill_q;
    prefetch_d = prefetch_q;
    ret_d      = ret_q;
    if (accept) begin
      narrow_d   = calc_narrow;
      link_d     = req_link;
      target_d   = calc_target;
      refill_d   = calc_refill;
      prefetch_d = calc_prefetch;
      ret_d      = calc_ret;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      narrow_q   <= 1'b0;
      link_q     <= 1'b0;
      target_q   <= '0;
      refill_q   <= '0;
      prefetch_q <= '0;
      ret_q      <= '0;
    end else begin
      narrow_q   <= narrow_d;
      link_q     <= link_d;
      target_q   <= target_d;
      refill_q   <= refill_d;
      prefetch_q <= prefetch_d;
      ret_q      <= ret_d;
    end
  end

  // per-phase output selection
  always_comb begin
    busy        = 1'b0;
    fetch_valid = 1'b0;
    fetch_addr  = '0;
    fetch_seq   = 1'b0;
    state_out   = cur_narrow;
    dside_en    = 1'b1;
    link_we     = 1'b0;
    link_data   = '0;
    unique case (phase)
      PH_C1: begin
        busy        = 1'b1;
        fetch_valid = 1'b1;
        fetch_addr  = prefetch_q;
        fetch_seq   = 1'b1;
        state_out   = narrow_q;
      end
      PH_C2: begin
        busy        = 1'b1;
        fetch_valid = 1'b1;
        fetch_addr  = target_q;
        state_out   = narrow_q;
        dside_en    = 1'b0;
        link_we     = link_q;
        link_data   = link_q ? ret_q : '0;
      end
      PH_C3: begin
        fetch_valid = 1'b1;
        fetch_addr  = refill_q;
        fetch_seq   = 1'b1;
        state_out   = narrow_q;
        dside_en    = 1'b0;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/bx_fetch_chk.sv
module bx_fetch_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_seq,
  input logic          state_out,
  input logic          dside_en,
  input logic          link_we
);

  // R1
  busy_has_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fetch_valid);

  // R3
  rise_then_nseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (busy && fetch_valid && !fetch_seq));

  // R4
  refill_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_seq) |=> (fetch_valid && fetch_seq && !busy));

  // R4
  refill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_seq) |=>
      (fetch_addr == $past(fetch_addr) + (state_out ? AW'(2) : AW'(4))));

  // R7
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_seq) |=> $stable(state_out));

  // R8
  link_in_c2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (fetch_valid && !fetch_seq));

  // R8
  link_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |=> !link_we);

  // R9
  dside_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dside_en |-> (fetch_valid && !busy || fetch_valid && !fetch_seq));

endmodule

bind bx_fetch_seq bx_fetch_chk #(.AW(AW)) chk_i (.*);

// File: tb/bx_fetch_seq_tb.sv
module bx_fetch_seq_tb_top;

  localparam int AW = 32;

  typedef struct {
    int          cyc;
    logic [31:0] addr;
    logic        seq;
    logic        st;
    logic        bsy;
    logic        dse;
    logic        lwe;
    logic [31:0] ldata;
    string       atag;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_imm, req_link, cur_narrow;
  logic [AW-1:0] cur_pc, reg_val, imm_off;
  logic          busy, fetch_valid, fetch_seq, state_out, dside_en, link_we;
  logic [AW-1:0] fetch_addr, link_data;

  item_t q[$];
  int    n_chk, n_fail;
  bit    done, mon_on;

  bx_fetch_seq #(.AW(AW)) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  function automatic void push_op(bit imm, bit lnk, bit old_n,
                                  logic [31:0] pc, logic [31:0] rv, logic [31:0] off);
    bit          nn;
    logic [31:0] ow, nw, d;
    item_t       it;
    nn = imm ? ~old_n : rv[0];
    ow = old_n ? 32'd2 : 32'd4;
    nw = nn ? 32'd2 : 32'd4;
    d  = imm ? pc + off : rv;
    d[0] = 1'b0;
    if (!nn) d[1] = 1'b0;
    it = '{1, pc + 2*ow, 1'b1, nn, 1'b1, 1'b1, 1'b0, 32'h0, "R2"};
    q.push_back(it);
    it = '{2, d, 1'b0, nn, 1'b1, 1'b0, lnk, lnk ? pc + ow : 32'h0, imm ? "R6" : "R5"};
    q.push_back(it);
    it = '{3, d + nw, 1'b1, nn, 1'b0, 1'b0, 1'b0, 32'h0, "R4"};
    q.push_back(it);
  endfunction

  task automatic drive(bit imm, bit lnk, bit old_n,
                       logic [31:0] pc, logic [31:0] rv, logic [31:0] off);
    req_valid  = 1'b1;
    req_imm    = imm;
    req_link   = lnk;
    cur_narrow = old_n;
    cur_pc     = pc;
    reg_val    = rv;
    imm_off    = off;
    push_op(imm, lnk, old_n, pc, rv, off);
  endtask

  // single request, then idle until the sequence is over
  task automatic issue(bit imm, bit lnk, bit old_n,
                       logic [31:0] pc, logic [31:0] rv, logic [31:0] off);
    @(negedge clk);
    drive(imm, lnk, old_n, pc, rv, off);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops one expected record per valid fetch cycle
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      #2;
      if (mon_on) begin
        if (fetch_valid) begin
          if (q.size() == 0) begin
            chk("R10", "unexpected fetch_valid", 32'(fetch_valid), 32'h0);
          end else begin
            e = q.pop_front();
            chk(e.atag, $sformatf("c%0d fetch_addr", e.cyc), fetch_addr, e.addr);
            chk(e.cyc == 2 ? "R3" : (e.cyc == 1 ? "R2" : "R4"),
                $sformatf("c%0d fetch_seq", e.cyc), 32'(fetch_seq), 32'(e.seq));
            chk("R7", $sformatf("c%0d state_out", e.cyc), 32'(state_out), 32'(e.st));
            chk("R1", $sformatf("c%0d busy", e.cyc), 32'(busy), 32'(e.bsy));
            chk("R9", $sformatf("c%0d dside_en", e.cyc), 32'(dside_en), 32'(e.dse));
            chk("R8", $sformatf("c%0d link_we", e.cyc), 32'(link_we), 32'(e.lwe));
            if (e.lwe) chk("R8", "link_data", link_data, e.ldata);
          end
        end else begin
          chk("R10", "idle busy", 32'(busy), 32'h0);
          chk("R7", "idle state_out", 32'(state_out), 32'(cur_narrow));
          chk("R9", "idle dside_en", 32'(dside_en), 32'h1);
          chk("R8", "idle link_we", 32'(link_we), 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; mon_on = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_imm = 1'b0; req_link = 1'b0;
    cur_narrow = 1'b0; cur_pc = '0; reg_val = '0; imm_off = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "reset fetch_valid", 32'(fetch_valid), 32'h0);
    chk("R10", "reset busy", 32'(busy), 32'h0);
    chk("R10", "reset link_we", 32'(link_we), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R5 register form, every old/new state and link choice
    for (int o = 0; o < 2; o++) begin
      for (int n = 0; n < 2; n++) begin
        for (int l = 0; l < 2; l++) begin
          issue(1'b0, l[0], o[0], 32'h0000_1000 + 32'(o*16),
                {28'h0004_567, 2'b01, 1'b1, n[0]}, 32'h0);
          repeat (4) @(negedge clk);
        end
      end
    end

    // R6 immediate form, forward and backward offsets
    for (int o = 0; o < 2; o++) begin
      for (int l = 0; l < 2; l++) begin
        issue(1'b1, l[0], o[0], 32'h0000_8000, 32'h0, 32'h0000_0127);
        repeat (4) @(negedge clk);
        issue(1'b1, l[0], o[0], 32'h0000_8004, 32'h0, 32'hFFFF_FF02);
        repeat (4) @(negedge clk);
      end
    end

    // R1 request held during cycles 1 and 2 is ignored
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_3001, 32'h0);
    @(negedge clk);
    reg_val = 32'h0000_7776; cur_pc = 32'h0000_9990; req_imm = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);

    // R11 back-to-back: second request presented in cycle 3
    issue(1'b0, 1'b0, 1'b1, 32'h0000_4002, 32'h0000_5000, 32'h0);
    @(negedge clk);
    issue(1'b1, 1'b1, 1'b0, 32'h0000_6000, 32'h0, 32'h0000_0040);
    @(negedge clk);
    @(negedge clk);
    issue(1'b0, 1'b1, 1'b1, 32'h0000_6102, 32'h0000_0A0B, 32'h0);
    repeat (5) @(negedge clk);

    chk("R11", "pending expected records", 32'(q.size()), 32'h0);
    done = 1'b1;
    summary();
  end

endmodule